// File: doc/BRIEF.md
# Program-flash security gate

This block sits between an external programming and read port and a program-flash array. It filters every external operation with a security flag that is stored in a one-byte option register. That register is the byte at the highest flash address. The block also decodes the other option bits into static control outputs for the rest of the chip. A second request port serves trusted in-system update code. Requests on that port are never filtered by the security flag. The array is a simple behavioural memory with one synchronous port. Programming pulse timing is not modelled.

The option byte is read from the array when reset is released. After that, an internal copy follows every accepted write to that byte and every erase that covers it. Erasing sets bytes to 0x00, one page at a time or the whole array at once. An erase occupies the array for one cycle per byte, and the block reports itself busy for that time. An external mass erase is always allowed. It is the only external way to drop security. When an external request is rejected, the block raises a one-cycle error pulse and sends no command to the array.

Top module: `flash_sec_gate`

## Requirements
- R1: The option byte is the byte at flash address all-ones. Its bit 5 drives `secure`, bit 2 drives `wdog_off`, bit 1 drives `halt_off` and bit 0 drives `boot_flash`. The outputs follow the stored byte from the cycle after it changes. The byte is read back from the array after every reset release, and `busy` is high while that load is in progress.
- R2: While secure, an external read of any address other than the alias returns 0xFF, including the option byte's own address. When not secure, an in-range external read returns the stored byte. An external read outside the flash range that is not the alias always returns 0xFF.
- R3: An external read of the alias address (all ones on the external address) returns the stored option byte whatever the security state.
- R4: While secure, external byte writes and external page erases are rejected with `req_err` and leave the array unchanged.
- R5: An external mass erase is accepted in every security state. It sets every byte to 0x00, which clears `secure`.
- R6: A page erase sets the 2^PAGE_W-byte aligned page that holds the given address to 0x00 and keeps `busy` high for 2^PAGE_W cycles. A mass erase keeps `busy` high for 2^ADDR_W cycles.
- R7: Reads, writes and erases on the user port ignore the security flag.
- R8: A write to the option byte, from either port, is accepted only if the last page has been erased since the last accepted write into that page. Otherwise it is rejected with `req_err`. After reset this condition counts as not met.
- R9: Any request made while `busy` is high is rejected with `req_err` and has no effect.
- R10: `req_err` pulses in the cycle after the clock edge that samples a rejected request. `rd_valid` pulses with `rd_data` one cycle later than that, that is, two edges after the read is sampled.
- R11: An external write to the alias address or to an address outside the flash range is rejected with `req_err`.
- R12: A user request has precedence over an external request in the same cycle. The external request is then rejected with `req_err`. Within one port, strobes rank mass erase, then page erase, then write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rd | input | 1 | External read strobe |
| ext_wr | input | 1 | External byte write strobe |
| ext_pe | input | 1 | External page erase strobe |
| ext_me | input | 1 | External mass erase strobe |
| ext_addr | input | EXT_W | External byte address |
| ext_wdata | input | 8 | External write data |
| usr_rd | input | 1 | User port read strobe |
| usr_wr | input | 1 | User port write strobe |
| usr_pe | input | 1 | User port page erase strobe |
| usr_me | input | 1 | User port mass erase strobe |
| usr_addr | input | ADDR_W | User port byte address |
| usr_wdata | input | 8 | User port write data |
| rd_valid | output | 1 | Read data valid pulse (both ports) |
| rd_data | output | 8 | Read data, possibly replaced by 0xFF |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| busy | output | 1 | Option load or erase in progress |
| secure | output | 1 | Option bit 5 |
| wdog_off | output | 1 | Option bit 2 |
| halt_off | output | 1 | Option bit 1 |
| boot_flash | output | 1 | Option bit 0 |

## Verification
Assertions check four things on every cycle: a secured external read that does not use the alias is answered with 0xFF two edges later; a secured external write or page erase never reaches the array and always raises an error; a request made while busy is rejected; and the array never receives an option-byte write while the erased-page condition is unmet. Only the bench's scenarios can show the rest. These are the byte contents that survive page and mass erases, the exact length of `busy`, the reload of the option byte after a second reset, and the precedence of the user port, each compared against a reference copy of the array kept in the bench.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD,
    OP_WR,
    OP_PE,
    OP_ME
  } op_e;

  typedef enum logic [1:0] {
    ST_BOOT_RD,
    ST_BOOT_LD,
    ST_IDLE,
    ST_ERASE
  } gate_st_e;

  function automatic op_e pick_op(input logic me, input logic pe,
                                  input logic wr, input logic rd);
    if (me)      return OP_ME;
    else if (pe) return OP_PE;
    else if (wr) return OP_WR;
    else if (rd) return OP_RD;
    else         return OP_NONE;
  endfunction
endpackage

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/fsg_eraser.sv
module fsg_eraser #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              whole,
  input  logic [ADDR_W-1:0] base,
  output logic              active,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);
  localparam int PG_HI = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      last   <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= whole ? '0 : {base[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
      last   <= whole ? '1 : {base[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (cnt == last) active <= 1'b0;
    end
  end

  assign wr_addr = cnt;
  assign done    = active && (cnt == last);

  assert_erase_in_page_R6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(done)) |->
      (cnt[ADDR_W-1:PAGE_W] == $past(cnt[ADDR_W-1:PAGE_W]) || last == '1))
    else $error("erase walked out of its page");

  localparam int UNUSED_PG = PG_HI;
endmodule

// File: rtl/fsg_policy.sv
module fsg_policy
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int EXT_W  = 16
) (
  input  logic              idle,
  input  logic              secure,
  input  logic              clean,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic              ext_pe,
  input  logic              ext_me,
  input  logic [EXT_W-1:0]  ext_addr,
  input  logic              usr_rd,
  input  logic              usr_wr,
  input  logic              usr_pe,
  input  logic              usr_me,
  input  logic [ADDR_W-1:0] usr_addr,
  output op_e               op,
  output logic              from_usr,
  output logic [ADDR_W-1:0] tgt,
  output logic              force_ff,
  output logic              err
);
  localparam logic [ADDR_W-1:0] OPT_ADDR = '1;

  op_e ext_op, usr_op;
  logic in_rng, alias_hit;
  logic [ADDR_W-1:0] ext_lo;

  always_comb begin
    ext_op    = pick_op(ext_me, ext_pe, ext_wr, ext_rd);
    usr_op    = pick_op(usr_me, usr_pe, usr_wr, usr_rd);
    in_rng    = (ext_addr[EXT_W-1:ADDR_W] == '0);
    alias_hit = &ext_addr;
    ext_lo    = ext_addr[ADDR_W-1:0];

    op       = OP_NONE;
    from_usr = 1'b0;
    tgt      = '0;
    force_ff = 1'b0;
    err      = 1'b0;

    if (!idle) begin
      err = (usr_op != OP_NONE) || (ext_op != OP_NONE);
    end else if (usr_op != OP_NONE) begin
      from_usr = 1'b1;
      tgt      = usr_addr;
      err      = (ext_op != OP_NONE);
      if (usr_op == OP_WR && usr_addr == OPT_ADDR && !clean) err = 1'b1;
      else op = usr_op;
    end else begin
      case (ext_op)
        OP_RD: begin
          op = OP_RD;
          if (alias_hit) tgt = OPT_ADDR;
          else begin
            tgt      = ext_lo;
            force_ff = !in_rng || secure;
          end
        end
        OP_WR: begin
          if (secure || !in_rng || (ext_lo == OPT_ADDR && !clean)) err = 1'b1;
          else begin
            op  = OP_WR;
            tgt = ext_lo;
          end
        end
        OP_PE: begin
          if (secure || !in_rng) err = 1'b1;
          else begin
            op  = OP_PE;
            tgt = ext_lo;
          end
        end
        OP_ME:   op = OP_ME;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7,
  parameter int EXT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic              ext_pe,
  input  logic              ext_me,
  input  logic [EXT_W-1:0]  ext_addr,
  input  logic [7:0]        ext_wdata,
  input  logic              usr_rd,
  input  logic              usr_wr,
  input  logic              usr_pe,
  input  logic              usr_me,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [7:0]        usr_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              req_err,
  output logic              busy,
  output logic              secure,
  output logic              wdog_off,
  output logic              halt_off,
  output logic              boot_flash
);
  localparam logic [ADDR_W-1:0] OPT_ADDR = '1;
  localparam int SEC_BIT  = 5;
  localparam int WDOG_BIT = 2;
  localparam int HALT_BIT = 1;
  localparam int BOOT_BIT = 0;

  gate_st_e state;
  logic [7:0] shadow;
  logic clean;
  logic pend_v, pend_ff;
  logic er_mass, er_last;

  op_e op;
  logic from_usr, force_ff, pol_err;
  logic [ADDR_W-1:0] tgt;
  logic [7:0] wsel;

  logic arr_rd, arr_wr;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata;

  logic er_start, er_active, er_done;
  logic [ADDR_W-1:0] er_addr;

  logic usr_any, ext_any, idle;

  assign idle    = (state == ST_IDLE);
  assign usr_any = usr_rd | usr_wr | usr_pe | usr_me;
  assign ext_any = ext_rd | ext_wr | ext_pe | ext_me;

  fsg_policy #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_policy (
    .idle(idle), .secure(shadow[SEC_BIT]), .clean(clean),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_pe(ext_pe), .ext_me(ext_me),
    .ext_addr(ext_addr),
    .usr_rd(usr_rd), .usr_wr(usr_wr), .usr_pe(usr_pe), .usr_me(usr_me),
    .usr_addr(usr_addr),
    .op(op), .from_usr(from_usr), .tgt(tgt), .force_ff(force_ff), .err(pol_err)
  );

  assign wsel     = from_usr ? usr_wdata : ext_wdata;
  assign er_start = idle && (op == OP_PE || op == OP_ME);

  fsg_eraser #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eraser (
    .clk(clk), .rst(rst), .start(er_start), .whole(op == OP_ME), .base(tgt),
    .active(er_active), .wr_addr(er_addr), .done(er_done)
  );

  always_comb begin
    arr_rd    = 1'b0;
    arr_wr    = 1'b0;
    arr_addr  = tgt;
    arr_wdata = wsel;
    case (state)
      ST_ERASE: begin
        arr_wr    = er_active;
        arr_addr  = er_addr;
        arr_wdata = 8'h00;
      end
      ST_BOOT_RD: begin
        arr_rd   = 1'b1;
        arr_addr = OPT_ADDR;
      end
      ST_IDLE: begin
        arr_rd = (op == OP_RD) && !force_ff;
        arr_wr = (op == OP_WR);
      end
      default: ;
    endcase
  end

  fsg_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rd_en(arr_rd), .wr_en(arr_wr), .addr(arr_addr),
    .wdata(arr_wdata), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_BOOT_RD;
      shadow   <= 8'h00;
      clean    <= 1'b0;
      pend_v   <= 1'b0;
      pend_ff  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      req_err  <= 1'b0;
      er_mass  <= 1'b0;
      er_last  <= 1'b0;
    end else begin
      req_err  <= pol_err;
      pend_v   <= idle && (op == OP_RD);
      pend_ff  <= force_ff;
      rd_valid <= pend_v;
      if (pend_v) rd_data <= pend_ff ? 8'hFF : arr_rdata;
      case (state)
        ST_BOOT_RD: state <= ST_BOOT_LD;
        ST_BOOT_LD: begin
          shadow <= arr_rdata;
          state  <= ST_IDLE;
        end
        ST_IDLE: begin
          if (op == OP_WR) begin
            if (tgt == OPT_ADDR) shadow <= wsel;
            if (&tgt[ADDR_W-1:PAGE_W]) clean <= 1'b0;
          end
          if (er_start) begin
            state   <= ST_ERASE;
            er_mass <= (op == OP_ME);
            er_last <= (op == OP_ME) || (&tgt[ADDR_W-1:PAGE_W]);
          end
        end
        ST_ERASE: begin
          if (er_done) begin
            state <= ST_IDLE;
            if (er_last) begin
              clean  <= 1'b1;
              shadow <= 8'h00;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = !idle;
  assign secure     = shadow[SEC_BIT];
  assign wdog_off   = shadow[WDOG_BIT];
  assign halt_off   = shadow[HALT_BIT];
  assign boot_flash = shadow[BOOT_BIT];

  assert_secure_read_ff_R2: assert property (@(posedge clk) disable iff (rst)
    (idle && secure && !usr_any && ext_rd && !ext_wr && !ext_pe && !ext_me && !(&ext_addr))
      |=> ##1 (rd_valid && rd_data == 8'hFF))
    else $error("secured external read not replaced");

  assert_secure_no_array_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && secure && !usr_any && !ext_me && (ext_wr || ext_pe)) |-> !arr_wr)
    else $error("secured external change reached the array");

  assert_secure_err_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && secure && !usr_any && !ext_me && (ext_wr || ext_pe)) |=> (req_err && !busy))
    else $error("secured external change not rejected");

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && (usr_any || ext_any)) |=> req_err)
    else $error("request during busy not rejected");

  assert_opt_needs_erase_R8: assert property (@(posedge clk) disable iff (rst)
    (idle && arr_wr && arr_addr == OPT_ADDR) |-> clean)
    else $error("option byte written without prior erase");

  assert_mass_unsecures_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_ERASE && idle && $past(er_mass)) |-> !secure)
    else $error("mass erase left security set");
endmodule

// File: tb/flash_sec_gate_tb.sv
module flash_sec_gate_tb;
  localparam int AW = 9;
  localparam int PW = 7;
  localparam int EW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE = 1 << PW;
  localparam logic [AW-1:0] OPT = '1;
  localparam logic [EW-1:0] ALIAS = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rd = 0, ext_wr = 0, ext_pe = 0, ext_me = 0;
  logic [EW-1:0] ext_addr = '0;
  logic [7:0] ext_wdata = '0;
  logic usr_rd = 0, usr_wr = 0, usr_pe = 0, usr_me = 0;
  logic [AW-1:0] usr_addr = '0;
  logic [7:0] usr_wdata = '0;
  logic rd_valid, req_err, busy, secure, wdog_off, halt_off, boot_flash;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [7:0] refm [DEPTH];

  always #10 clk = ~clk;

  flash_sec_gate #(.ADDR_W(AW), .PAGE_W(PW), .EXT_W(EW)) u_dut (
    .clk(clk), .rst(rst),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_pe(ext_pe), .ext_me(ext_me),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .usr_rd(usr_rd), .usr_wr(usr_wr), .usr_pe(usr_pe), .usr_me(usr_me),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .req_err(req_err), .busy(busy),
    .secure(secure), .wdog_off(wdog_off), .halt_off(halt_off), .boot_flash(boot_flash)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    ext_rd = 0; ext_wr = 0; ext_pe = 0; ext_me = 0;
    usr_rd = 0; usr_wr = 0; usr_pe = 0; usr_me = 0;
  endtask

  // kind: 0 read, 1 write, 2 page erase, 3 mass erase
  task automatic do_req(input bit usr, input int kind, input logic [EW-1:0] a,
                        input logic [7:0] d, output bit err, output bit rv,
                        output logic [7:0] rdat, output int bcnt);
    @(negedge clk);
    if (usr) begin
      usr_addr = a[AW-1:0]; usr_wdata = d;
      usr_rd = (kind == 0); usr_wr = (kind == 1); usr_pe = (kind == 2); usr_me = (kind == 3);
    end else begin
      ext_addr = a; ext_wdata = d;
      ext_rd = (kind == 0); ext_wr = (kind == 1); ext_pe = (kind == 2); ext_me = (kind == 3);
    end
    @(posedge clk);
    @(negedge clk);
    clear_req();
    err = req_err;
    bcnt = busy ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    rv = rd_valid;
    rdat = rd_data;
    if (busy) bcnt++;
    while (busy) begin
      @(negedge clk);
      if (busy) bcnt++;
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic wait_boot();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e, v;
    logic [7:0] r;
    int bc;

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rd_valid", rd_valid, 0);
    chk("R10 reset req_err", req_err, 0);
    chk("R1 busy during reset", busy, 1);
    wait_boot();

    // R5 / R6: external mass erase, full-array busy length
    do_req(0, 3, '0, 0, e, v, r, bc);
    chk("R5 mass erase accepted", e, 0);
    chk("R6 mass erase busy cycles", bc, DEPTH);
    chk("R5 secure clear", secure, 0);
    for (int a = 0; a < DEPTH; a++) refm[a] = 8'h00;
    do_req(0, 0, EW'(100), 0, e, v, r, bc);
    chk("R5 erased reads zero", r, 0);
    chk("R10 rd_valid pulse", v, 1);

    // R1 / R8: option write after erase, second write refused
    do_req(0, 1, EW'(OPT), 8'h07, e, v, r, bc);
    chk("R8 option write accepted", e, 0);
    chk("R1 wdog_off", wdog_off, 1);
    chk("R1 halt_off", halt_off, 1);
    chk("R1 boot_flash", boot_flash, 1);
    chk("R1 secure", secure, 0);
    refm[OPT] = 8'h07;
    do_req(0, 1, EW'(OPT), 8'h20, e, v, r, bc);
    chk("R8 option rewrite refused", e, 1);
    chk("R8 secure unchanged", secure, 0);

    // R2: pattern sweep, unsecured
    for (int a = 0; a < DEPTH - 1; a++) begin
      do_req(0, 1, EW'(a), pat(a), e, v, r, bc);
      chk("R2 write ok", e, 0);
      refm[a] = pat(a);
    end
    for (int a = 0; a < DEPTH; a++) begin
      do_req(0, 0, EW'(a), 0, e, v, r, bc);
      chk("R2 unsecured read", r, refm[a]);
    end

    // R6: page erase of page 1
    do_req(0, 2, EW'(PAGE + 5), 0, e, v, r, bc);
    chk("R6 page erase busy cycles", bc, PAGE);
    for (int a = PAGE; a < 2 * PAGE; a++) refm[a] = 8'h00;
    for (int a = 0; a < DEPTH; a++) begin
      do_req(0, 0, EW'(a), 0, e, v, r, bc);
      chk("R6 page erase contents", r, refm[a]);
    end

    // R11 / R2: alias and out-of-range handling
    do_req(0, 1, ALIAS, 8'h11, e, v, r, bc);
    chk("R11 alias write refused", e, 1);
    do_req(0, 1, EW'(DEPTH), 8'h11, e, v, r, bc);
    chk("R11 out-of-range write refused", e, 1);
    do_req(0, 0, EW'(DEPTH + 3), 0, e, v, r, bc);
    chk("R2 out-of-range read", r, 8'hFF);

    // erase last page, then set security
    do_req(0, 2, EW'(DEPTH - 20), 0, e, v, r, bc);
    for (int a = DEPTH - PAGE; a < DEPTH; a++) refm[a] = 8'h00;
    chk("R6 last page erase clears option", wdog_off, 0);
    do_req(0, 1, EW'(OPT), 8'h26, e, v, r, bc);
    chk("R8 option write after page erase", e, 0);
    refm[OPT] = 8'h26;
    chk("R1 secure set", secure, 1);
    chk("R1 wdog_off set", wdog_off, 1);
    chk("R1 boot_flash clear", boot_flash, 0);

    // R2 / R3: secured reads
    for (int a = 0; a < DEPTH; a++) begin
      do_req(0, 0, EW'(a), 0, e, v, r, bc);
      chk("R2 secured read", r, 8'hFF);
    end
    do_req(0, 0, ALIAS, 0, e, v, r, bc);
    chk("R3 alias read", r, 8'h26);

    // R4: secured changes refused
    do_req(0, 1, EW'(3), 8'h99, e, v, r, bc);
    chk("R4 secured write refused", e, 1);
    do_req(0, 2, EW'(3), 0, e, v, r, bc);
    chk("R4 secured page erase refused", e, 1);
    chk("R4 no busy", bc, 0);

    // R7: user port sees real contents
    for (int a = 0; a < DEPTH; a++) begin
      do_req(1, 0, EW'(a), 0, e, v, r, bc);
      chk("R7 user read", r, refm[a]);
    end
    do_req(1, 1, EW'(4), 8'hA5, e, v, r, bc);
    chk("R7 user write accepted", e, 0);
    do_req(1, 0, EW'(4), 0, e, v, r, bc);
    chk("R7 user write data", r, 8'hA5);
    do_req(1, 2, EW'(4), 0, e, v, r, bc);
    chk("R7 user page erase busy", bc, PAGE);
    for (int a = 0; a < PAGE; a++) refm[a] = 8'h00;
    do_req(1, 0, EW'(4), 0, e, v, r, bc);
    chk("R7 user page erased", r, 0);
    do_req(1, 1, EW'(OPT), 8'h21, e, v, r, bc);
    chk("R8 user option rewrite refused", e, 1);

    // R1: reload after reset
    wait_boot();
    chk("R1 reload secure", secure, 1);
    chk("R1 reload halt_off", halt_off, 1);
    chk("R1 reload boot_flash", boot_flash, 0);

    // R12: user wins over external in the same cycle
    @(negedge clk);
    ext_addr = '0; ext_rd = 1;
    usr_addr = AW'(10); usr_wdata = 8'h3C; usr_wr = 1;
    @(posedge clk);
    @(negedge clk);
    clear_req();
    chk("R12 external loser flagged", req_err, 1);
    @(negedge clk);
    chk("R12 no external read", rd_valid, 0);
    refm[10] = 8'h3C;
    do_req(1, 0, EW'(10), 0, e, v, r, bc);
    chk("R12 user write landed", r, 8'h3C);

    // R9 / R5: request during busy, mass erase while secure
    @(negedge clk);
    ext_me = 1;
    @(posedge clk);
    @(negedge clk);
    clear_req();
    chk("R5 mass erase while secure", req_err, 0);
    usr_addr = AW'(5); usr_wdata = 8'h55; usr_wr = 1;
    @(posedge clk);
    @(negedge clk);
    clear_req();
    chk("R9 busy request refused", req_err, 1);
    while (busy) @(negedge clk);
    chk("R5 secure cleared", secure, 0);
    for (int a = 0; a < DEPTH; a++) begin
      do_req(0, 0, EW'(a), 0, e, v, r, bc);
      chk("R5 all zero", r, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule